// File: doc/BRIEF.md
# Cluster-Local Remote Subblock Buffer

Each cluster of a clustered processor sits next to one module of a word-interleaved data cache. When the cluster reads a word that lives in another module, the remote lookup returns the whole subblock that module holds for that cache block. For example, with four modules, module 3 holds words 3 and 7 of each block. This buffer keeps such subblocks close to the cluster. A later access to the other word of the same subblock, such as a stride-16-byte walk that touches a[3] and then a[7], then completes with local latency and does not cross the interconnect again.

The buffer has four fully associative entries. Each entry is tagged by block address and home module, and entries are replaced in least-recently-used order. Read-only copies of one subblock may exist in several clusters at once. A store broadcasts an invalidate so that written data lives in at most one buffer. A store that hits also updates the entry and writes through to the home module. The compiler issues a one-cycle flush at loop end, which empties the buffer. The cache modules and the interconnect are outside the block: they deliver fills and incoming invalidates, and they consume write-throughs and outgoing invalidates.

Top module: `attractionBuffer`

## Requirements
- R1: After reset every entry is invalid, `rspValid`, `wtValid` and `invOutValid` are 0, and `reqReady` is 1 while `flushReq` and `fillValid` are low.
- R2: An accepted load whose block and module match a valid entry gives, on the next cycle, `rspValid`=1, `rspHit`=1 and `rspData` set to the requested word.
- R3: An accepted load that matches no valid entry gives `rspValid`=1, `rspHit`=0 and `rspData`=0 on the next cycle. On every other cycle `rspData` is 0.
- R4: A fill writes the whole subblock into one entry. Word w of the subblock is `fillLine[w*DATA_W +: DATA_W]`. A fill whose tag is already held overwrites that entry, so the tag is never duplicated.
- R5: A fill with no matching entry uses an invalid entry if one exists. Otherwise it evicts the entry least recently touched, where loads that hit, stores that hit and fills all count as touches.
- R6: A store that hits updates that word in the entry. On the next cycle it raises `wtValid` with the store's block, module, word and data. A store that misses raises no write-through and allocates no entry.
- R7: Every accepted store raises `invOutValid` on the next cycle, with its block and module on `invOutBlock` and `invOutModule`.
- R8: An incoming invalidate clears a matching entry at the end of its cycle. A request in that same cycle to the same subblock misses, and a fill for the same subblock in that cycle is discarded.
- R9: While `flushReq` is high, `reqReady` is 0, no request is accepted, a fill in that cycle is dropped, and all entries become invalid.
- R10: When `fillValid` is high, `reqReady` is 0. The fill is taken and the request must be presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flushReq | input | 1 | Loop-end flush, one cycle |
| reqValid | input | 1 | Cluster request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqBlock | input | BLK_W | Block address of the request |
| reqModule | input | MOD_W | Home module of the requested word |
| reqWord | input | WORD_W | Word index within the subblock |
| reqWdata | input | DATA_W | Store data |
| reqReady | output | 1 | Request accepted this cycle when high |
| fillValid | input | 1 | Remote hit delivering a subblock |
| fillBlock | input | BLK_W | Block address of the fill |
| fillModule | input | MOD_W | Home module of the fill |
| fillLine | input | SUB_WORDS*DATA_W | Subblock words, word 0 in the low bits |
| invInValid | input | 1 | Invalidate from another cluster |
| invInBlock | input | BLK_W | Block address to invalidate |
| invInModule | input | MOD_W | Module of the subblock to invalidate |
| rspValid | output | 1 | Response to the request accepted last cycle |
| rspHit | output | 1 | That request hit in the buffer |
| rspData | output | DATA_W | Load data on a load hit, else 0 |
| wtValid | output | 1 | Write-through of a store hit |
| wtBlock | output | BLK_W | Write-through block |
| wtModule | output | MOD_W | Write-through home module |
| wtWord | output | WORD_W | Write-through word index |
| wtData | output | DATA_W | Write-through data |
| invOutValid | output | 1 | Invalidate broadcast for a store |
| invOutBlock | output | BLK_W | Broadcast block |
| invOutModule | output | MOD_W | Broadcast module |

## Verification
The collision that matters most is an incoming invalidate landing in the same cycle as a lookup or a fill of the same subblock. The invalidate must win in both cases, so the lookup misses and the fill is lost. Directed steps line up that collision on a held tag and on a tag about to be filled. The random phase then draws invalidates from the same small tag space as requests and fills, so such overlaps recur often. Each response is judged against a bench model that removes invalidated entries before it resolves the lookup or picks the fill victim. A flush that coincides with a request or a fill is provoked the same way and judged by `reqReady`, by an absent response, and by a miss on the following load.

// File: rtl/abPkg.sv
package abPkg;

  // Per-cycle operation chosen by the control; at most one is set.
  typedef struct packed {
    logic flush;
    logic fill;
    logic load;
    logic store;
  } abStrobe_t;

endpackage

// File: rtl/abCtrl.sv
module abCtrl
  import abPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      flushReq,
  input  logic      fillValid,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output abStrobe_t strb
);

  // Flush beats fill, fill beats a cluster request.
  always_comb begin
    reqReady   = !flushReq && !fillValid;
    strb.flush = flushReq;
    strb.fill  = fillValid && !flushReq;
    strb.load  = reqValid && reqReady && !reqWrite;
    strb.store = reqValid && reqReady && reqWrite;
  end

  // R10 / R9: never more than one operation per cycle
  assert_one_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R9: a flush cycle leaves the request unaccepted
  assert_flush_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !(strb.load || strb.store || strb.fill));

endmodule

// File: rtl/abData.sv
module abData
  import abPkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int BLK_W     = 8,
  parameter int MOD_W     = 2,
  parameter int SUB_WORDS = 2,
  parameter int WORD_W    = 1,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LINE_W   = SUB_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  abStrobe_t         strb,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [MOD_W-1:0]  reqModule,
  input  logic [WORD_W-1:0] reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BLK_W-1:0]  fillBlock,
  input  logic [MOD_W-1:0]  fillModule,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              invInValid,
  input  logic [BLK_W-1:0]  invInBlock,
  input  logic [MOD_W-1:0]  invInModule,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              wtValid,
  output logic [BLK_W-1:0]  wtBlock,
  output logic [MOD_W-1:0]  wtModule,
  output logic [WORD_W-1:0] wtWord,
  output logic [DATA_W-1:0] wtData,
  output logic              invOutValid,
  output logic [BLK_W-1:0]  invOutBlock,
  output logic [MOD_W-1:0]  invOutModule
);

  logic [ENTRIES-1:0] vld;
  logic [BLK_W-1:0]   blk  [ENTRIES];
  logic [MOD_W-1:0]   mod  [ENTRIES];
  logic [LINE_W-1:0]  line [ENTRIES];
  logic [IDX_W-1:0]   age  [ENTRIES];

  logic [ENTRIES-1:0] invHit, liveVld, reqHit, fillHit, oldest;

  function automatic logic [IDX_W-1:0] firstSet(input logic [ENTRIES-1:0] v);
    firstSet = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) firstSet = IDX_W'(i);
  endfunction

  // Tag comparators, one set per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign invHit[g]  = invInValid && vld[g] && blk[g] == invInBlock && mod[g] == invInModule;
    assign liveVld[g] = vld[g] && !invHit[g];
    assign reqHit[g]  = liveVld[g] && blk[g] == reqBlock && mod[g] == reqModule;
    assign fillHit[g] = liveVld[g] && blk[g] == fillBlock && mod[g] == fillModule;
    assign oldest[g]  = age[g] == IDX_W'(ENTRIES - 1);

    // R8: an invalidated subblock is gone one cycle later
    assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      invHit[g] |=> !(vld[g] && blk[g] == $past(invInBlock) && mod[g] == $past(invInModule)));
  end

  logic             fillKill, fillDo, anyHit, touchEn, isReq;
  logic [IDX_W-1:0] reqIdx, victimIdx, touchIdx;

  always_comb begin
    fillKill  = invInValid && invInBlock == fillBlock && invInModule == fillModule;
    fillDo    = strb.fill && !fillKill;
    anyHit    = |reqHit;
    reqIdx    = firstSet(reqHit);
    isReq     = strb.load || strb.store;
    if (|fillHit)        victimIdx = firstSet(fillHit);
    else if (!(&liveVld)) victimIdx = firstSet(~liveVld);
    else                 victimIdx = firstSet(oldest);
    touchEn   = fillDo || (isReq && anyHit);
    touchIdx  = fillDo ? victimIdx : reqIdx;
  end

  // Valid bits and recency order.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (strb.flush) begin
      vld <= '0;
    end else begin
      vld <= liveVld;
      if (fillDo) vld[victimIdx] <= 1'b1;
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx)      age[i] <= '0;
          else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  // Tags and data carry no reset.
  always_ff @(posedge clk) begin
    if (fillDo) begin
      blk[victimIdx]  <= fillBlock;
      mod[victimIdx]  <= fillModule;
      line[victimIdx] <= fillLine;
    end else if (strb.store && anyHit) begin
      line[reqIdx][reqWord*DATA_W +: DATA_W] <= reqWdata;
    end
  end

  // Registered responses: one cycle after acceptance.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspData      <= '0;
      wtValid      <= 1'b0;
      wtBlock      <= '0;
      wtModule     <= '0;
      wtWord       <= '0;
      wtData       <= '0;
      invOutValid  <= 1'b0;
      invOutBlock  <= '0;
      invOutModule <= '0;
    end else begin
      rspValid     <= isReq;
      rspHit       <= isReq && anyHit;
      rspData      <= (strb.load && anyHit) ? line[reqIdx][reqWord*DATA_W +: DATA_W] : '0;
      wtValid      <= strb.store && anyHit;
      wtBlock      <= reqBlock;
      wtModule     <= reqModule;
      wtWord       <= reqWord;
      wtData       <= reqWdata;
      invOutValid  <= strb.store;
      invOutBlock  <= reqBlock;
      invOutModule <= reqModule;
    end
  end

  // R4: a tag is never held twice
  assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqHit) && $onehot0(fillHit));

  // R4: a taken fill leaves its entry valid
  assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fillDo && !strb.flush) |=> vld[$past(victimIdx)]);

  // R9: flush empties the buffer
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (vld == '0));

  // R2: a load hit answers on the following cycle
  assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && anyHit) |=> (rspValid && rspHit));

  // R6 / R7: write-through only for a store that hit, always with its broadcast
  assert_wt_on_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    wtValid |-> (rspValid && rspHit && invOutValid));

endmodule

// File: rtl/attractionBuffer.sv
module attractionBuffer
  import abPkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int BLK_W     = 8,
  parameter int MODULES   = 4,
  parameter int SUB_WORDS = 2,
  parameter int DATA_W    = 32,
  localparam int MOD_W    = (MODULES > 1) ? $clog2(MODULES) : 1,
  localparam int WORD_W   = (SUB_WORDS > 1) ? $clog2(SUB_WORDS) : 1,
  localparam int LINE_W   = SUB_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushReq,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [MOD_W-1:0]  reqModule,
  input  logic [WORD_W-1:0] reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              fillValid,
  input  logic [BLK_W-1:0]  fillBlock,
  input  logic [MOD_W-1:0]  fillModule,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              invInValid,
  input  logic [BLK_W-1:0]  invInBlock,
  input  logic [MOD_W-1:0]  invInModule,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              wtValid,
  output logic [BLK_W-1:0]  wtBlock,
  output logic [MOD_W-1:0]  wtModule,
  output logic [WORD_W-1:0] wtWord,
  output logic [DATA_W-1:0] wtData,
  output logic              invOutValid,
  output logic [BLK_W-1:0]  invOutBlock,
  output logic [MOD_W-1:0]  invOutModule
);

  abStrobe_t strb;

  abCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .flushReq  (flushReq),
    .fillValid (fillValid),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqReady  (reqReady),
    .strb      (strb)
  );

  abData #(
    .ENTRIES   (ENTRIES),
    .BLK_W     (BLK_W),
    .MOD_W     (MOD_W),
    .SUB_WORDS (SUB_WORDS),
    .WORD_W    (WORD_W),
    .DATA_W    (DATA_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqBlock     (reqBlock),
    .reqModule    (reqModule),
    .reqWord      (reqWord),
    .reqWdata     (reqWdata),
    .fillBlock    (fillBlock),
    .fillModule   (fillModule),
    .fillLine     (fillLine),
    .invInValid   (invInValid),
    .invInBlock   (invInBlock),
    .invInModule  (invInModule),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspData      (rspData),
    .wtValid      (wtValid),
    .wtBlock      (wtBlock),
    .wtModule     (wtModule),
    .wtWord       (wtWord),
    .wtData       (wtData),
    .invOutValid  (invOutValid),
    .invOutBlock  (invOutBlock),
    .invOutModule (invOutModule)
  );

endmodule

// File: tb/sim_attractionBuffer.sv
module sim_attractionBuffer;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushReq = 0, reqValid = 0, reqWrite = 0;
  logic [7:0]  reqBlock = 0;
  logic [1:0]  reqModule = 0;
  logic        reqWord = 0;
  logic [31:0] reqWdata = 0;
  logic        reqReady;
  logic        fillValid = 0;
  logic [7:0]  fillBlock = 0;
  logic [1:0]  fillModule = 0;
  logic [63:0] fillLine = 0;
  logic        invInValid = 0;
  logic [7:0]  invInBlock = 0;
  logic [1:0]  invInModule = 0;
  logic        rspValid, rspHit, wtValid, invOutValid;
  logic [31:0] rspData, wtData;
  logic [7:0]  wtBlock, invOutBlock;
  logic [1:0]  wtModule, invOutModule;
  logic        wtWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  attractionBuffer u0 (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBlock(reqBlock), .reqModule(reqModule), .reqWord(reqWord), .reqWdata(reqWdata),
    .reqReady(reqReady), .fillValid(fillValid), .fillBlock(fillBlock), .fillModule(fillModule),
    .fillLine(fillLine), .invInValid(invInValid), .invInBlock(invInBlock), .invInModule(invInModule),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData), .wtValid(wtValid), .wtBlock(wtBlock),
    .wtModule(wtModule), .wtWord(wtWord), .wtData(wtData), .invOutValid(invOutValid),
    .invOutBlock(invOutBlock), .invOutModule(invOutModule)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Reference model of the buffer
  bit          mVld [NE];
  logic [7:0]  mBlk [NE];
  logic [1:0]  mMod [NE];
  logic [63:0] mLine[NE];
  int          mAge [NE];

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic touch(input int k);
    int a = mAge[k];
    for (int i = 0; i < NE; i++) begin
      if (i == k) mAge[i] = 0;
      else if (mAge[i] < a) mAge[i]++;
    end
  endtask

  function automatic int pickVictim(input bit live[NE], input logic [7:0] b, input logic [1:0] m);
    for (int i = 0; i < NE; i++) if (live[i] && mBlk[i] == b && mMod[i] == m) return i;
    for (int i = 0; i < NE; i++) if (!live[i]) return i;
    for (int i = 0; i < NE; i++) if (mAge[i] == NE - 1) return i;
    return 0;
  endfunction

  // One cycle: drive at the falling edge, predict, check after the next falling edge.
  task automatic step(input bit fl, input bit fv, input logic [7:0] fb, input logic [1:0] fm,
                      input logic [63:0] fd, input bit rv, input bit rw, input logic [7:0] rb,
                      input logic [1:0] rm, input bit w, input logic [31:0] wd,
                      input bit iv, input logic [7:0] ib, input logic [1:0] im);
    bit live[NE];
    int hitIdx = -1;
    bit rdy, acc, reqKilled;
    logic [31:0] expData;
    string rtag;
    flushReq = fl; fillValid = fv; fillBlock = fb; fillModule = fm; fillLine = fd;
    reqValid = rv; reqWrite = rw; reqBlock = rb; reqModule = rm; reqWord = w; reqWdata = wd;
    invInValid = iv; invInBlock = ib; invInModule = im;
    rdy = !fl && !fv;
    acc = rv && rdy;
    reqKilled = iv && ib == rb && im == rm;
    for (int i = 0; i < NE; i++) begin
      live[i] = mVld[i] && !(iv && mBlk[i] == ib && mMod[i] == im);
      if (hitIdx < 0 && live[i] && mBlk[i] == rb && mMod[i] == rm) hitIdx = i;
    end
    expData = (acc && !rw && hitIdx >= 0) ? mLine[hitIdx][w*DW +: DW] : 32'd0;
    if (fl) rtag = "R9";
    else if (fv && rv) rtag = "R10";
    else if (reqKilled && rv) rtag = "R8";
    else if (rw) rtag = "R6";
    else if (hitIdx >= 0) rtag = "R2";
    else rtag = "R3";
    #1 chk(rtag, "reqReady", reqReady, rdy);
    // model update
    if (fl) begin
      for (int i = 0; i < NE; i++) mVld[i] = 0;
    end else begin
      for (int i = 0; i < NE; i++) mVld[i] = live[i];
      if (fv) begin
        if (!(iv && ib == fb && im == fm)) begin
          int v = pickVictim(live, fb, fm);
          mVld[v] = 1; mBlk[v] = fb; mMod[v] = fm; mLine[v] = fd;
          touch(v);
        end
      end else if (acc && hitIdx >= 0) begin
        touch(hitIdx);
        if (rw) mLine[hitIdx][w*DW +: DW] = wd;
      end
    end
    @(negedge clk);
    chk(rtag, "rspValid", rspValid, acc);
    chk(rtag, "rspHit", rspHit, acc && hitIdx >= 0);
    chk(rtag, "rspData", rspData, expData);
    chk("R6", "wtValid", wtValid, acc && rw && hitIdx >= 0);
    if (acc && rw && hitIdx >= 0)
      chk("R6", "wt fields", {wtBlock, wtModule, wtWord, wtData}, {rb, rm, w, wd});
    chk("R7", "invOutValid", invOutValid, acc && rw);
    if (acc && rw) chk("R7", "inv fields", {invOutBlock, invOutModule}, {rb, rm});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic load(input logic [7:0] b, input logic [1:0] m, input bit w);
    step(0, 0, 0, 0, 0, 1, 0, b, m, w, 0, 0, 0, 0);
  endtask
  task automatic store(input logic [7:0] b, input logic [1:0] m, input bit w, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 1, 1, b, m, w, d, 0, 0, 0);
  endtask
  task automatic fill(input logic [7:0] b, input logic [1:0] m, input logic [63:0] d);
    step(0, 1, b, m, d, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic flush();
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int localHits = 0;
    void'($urandom(32'd2024));
    for (int i = 0; i < NE; i++) begin mVld[i] = 0; mAge[i] = i; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rspValid", rspValid, 0);
    chk("R1", "wtValid", wtValid, 0);
    chk("R1", "invOutValid", invOutValid, 0);
    chk("R1", "reqReady", reqReady, 1);
    load(8'd0, 2'd3, 0);
    chk("R1", "first load misses", rspHit, 0);

    // R4: stride example, module 3 holds a[3] (word 0) and a[7] (word 1)
    fill(8'd0, 2'd3, {32'hA7, 32'hA3});
    load(8'd0, 2'd3, 0); chk("R4", "a3", rspData, 32'hA3); localHits += int'(rspHit);
    load(8'd0, 2'd3, 1); chk("R4", "a7", rspData, 32'hA7); localHits += int'(rspHit);
    chk("R4", "local hits", localHits, 2);
    fill(8'd0, 2'd3, {32'hB7, 32'hB3});
    load(8'd0, 2'd3, 1); chk("R4", "overwrite", rspData, 32'hB7);

    // R6: store hit updates and writes through; store miss allocates nothing
    store(8'd0, 2'd3, 0, 32'h1234);
    load(8'd0, 2'd3, 0); chk("R6", "updated word", rspData, 32'h1234);
    store(8'd9, 2'd1, 1, 32'h55);
    load(8'd9, 2'd1, 1); chk("R6", "no allocate", rspHit, 0);

    // R8: invalidate collides with a load and with a fill
    step(0, 0, 0, 0, 0, 1, 0, 8'd0, 2'd3, 0, 0, 1, 8'd0, 2'd3);
    chk("R8", "load during invalidate", rspHit, 0);
    load(8'd0, 2'd3, 0); chk("R8", "entry cleared", rspHit, 0);
    step(0, 1, 8'd5, 2'd2, 64'hF, 0, 0, 0, 0, 0, 0, 1, 8'd5, 2'd2);
    load(8'd5, 2'd2, 0); chk("R8", "fill discarded", rspHit, 0);

    // R9: flush with a request present
    fill(8'd6, 2'd1, 64'h66);
    step(1, 1, 8'd7, 2'd1, 64'h77, 1, 0, 8'd6, 2'd1, 0, 0, 0, 0, 0);
    chk("R9", "no response", rspValid, 0);
    load(8'd6, 2'd1, 0); chk("R9", "flushed", rspHit, 0);
    load(8'd7, 2'd1, 0); chk("R9", "fill dropped", rspHit, 0);

    // R10: fill and request together
    step(0, 1, 8'd3, 2'd0, 64'h33, 1, 0, 8'd3, 2'd0, 0, 0, 0, 0, 0);
    chk("R10", "request stalled", rspValid, 0);
    load(8'd3, 2'd0, 0); chk("R10", "retry hits", rspHit, 1);

    // R5: LRU order
    flush();
    fill(8'd10, 0, 64'hA); fill(8'd11, 0, 64'hB); fill(8'd12, 0, 64'hC); fill(8'd13, 0, 64'hD);
    load(8'd10, 0, 0);
    fill(8'd14, 0, 64'hE);
    load(8'd11, 0, 0); chk("R5", "oldest evicted", rspHit, 0);
    load(8'd10, 0, 0); chk("R5", "recent kept", rspHit, 1);
    load(8'd14, 0, 0); chk("R5", "new present", rspHit, 1);
    idle();

    // Random phase over a small tag space
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 16;
      bit fl = (r == 0);
      bit fv = ($urandom % 4) == 0;
      bit rv = ($urandom % 3) != 0;
      bit rw = ($urandom % 3) == 0;
      bit iv = ($urandom % 6) == 0;
      step(fl, fv, 8'($urandom % 4), 2'($urandom % 4), {$urandom, $urandom},
           rv, rw, 8'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2), $urandom,
           iv, 8'($urandom % 4), 2'($urandom % 4));
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule